// File: doc/BRIEF.md
# Auto-Reload Up-Counter with Gated Update Events

This block is a 16-bit up-counter driven through a prescaler. The reload limit, the prescale divisor and one compare value each sit behind a pair of registers. Host writes land in the preload copy. The live shadow copy takes the preload value only when an update event occurs. The one exception is the reload limit, which can be set to act at once. The counter runs from zero up to the shadow reload limit and then returns to zero. That wrap is an overflow, and an overflow is one source of update events.

The host reaches the block through a plain single-cycle register port: a write strobe with a write select and data, and a combinational read select. It can write a control word, the three preload values, a one-shot update-generate command and a flag-clear command. Two control bits decide what may start an update event and which events also set the sticky update flag. A separate enable decides whether the reload limit is buffered. The block also divides the timer clock into a sampling enable for later input filters. None of the pins carries a data stream, so there is no handshake or back-pressure. Each write takes effect at the clock edge where it is sampled.

The reset is asynchronous and active low. The counter width `CNT_W` must be at least 10 so that the control word fits.

Top module: `upd_timer`

Write select codes: 0 control, 1 reload preload, 2 prescale preload, 3 compare preload, 4 generate (data bit 0 = 1 issues it), 6 status (data bit 0 = 1 clears the flag). Read select codes: 0 control, 1 counter, 2 reload shadow, 3 prescale shadow, 4 compare shadow, 5 reload preload, 6 status (bit 0 = flag). Unused read codes return zero.

Control word bits: 0 enable, 1 update-suppress, 2 overflow-only flag, 7 reload buffering, 9:8 sampling divide code.

## Requirements
- R1: After reset, the control word reads 0, the counter reads 0, the flag is 0 and no update pulse is present.
- R2: With the enable bit at 0 the counter holds its value. With it at 1, the counter advances by one every (prescale shadow + 1) clocks.
- R3: The counter counts 0, 1, …, reload shadow. On the next prescaled tick it returns to 0 and signals overflow.
- R4: With reload buffering at 0, a reload write shows up in the reload shadow at the edge that samples the write.
- R5: With reload buffering at 1, the reload shadow keeps its value until an update event and then takes the preload value. The prescale and compare shadows always load only on an update event.
- R6: With update-suppress at 1, neither an overflow nor a generate command produces an update pulse or sets the flag. The shadows keep their values, but a generate command still returns the counter and prescaler to 0.
- R7: A generate command clears itself. The counter reads 0 in the cycle after the cycle in which the write was sampled. With update-suppress at 0, exactly one update event follows each command, whether or not counting is enabled.
- R8: With overflow-only flag at 0, both overflow and generate set the flag. With it at 1, only overflow sets the flag, although a generate command still produces the update pulse.
- R9: The flag stays at 1 until a status write with data bit 0 = 1. A status write with bit 0 = 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R10: Each update event produces an update pulse exactly one clock long, in the cycle after the event. In that same cycle the shadows show their new values.
- R11: The sampling enable is high on every clock for divide codes 00 and 11, on every 2nd clock for code 01, and on every 4th clock for code 10.
- R12: Control bits 15:10 and 6:3 are not stored and read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Write strobe, sampled at the rising edge |
| host_wsel_i | input | 3 | Write select code |
| host_wdata_i | input | CNT_W | Write data |
| host_rsel_i | input | 3 | Read select code |
| host_rdata_o | output | CNT_W | Combinational read data |
| uev_o | output | 1 | One-clock update-event pulse |
| upd_flag_o | output | 1 | Sticky update flag |
| filt_tick_o | output | 1 | Sampling enable for input filters |

## Verification
The hardest condition to reach from the ports is a generate command under update-suppress while the counter is running and preloads differ from shadows. The expected result is a zeroed counter, no pulse and unchanged shadows. The stimulus starts from a known state: the prescaler and counter are zeroed by an unsuppressed generate and the flag is cleared. The bench then turns on counting with suppress and buffering set, and writes fresh preloads. It issues the command and samples the counter, pulse and every shadow readback in the following cycle. Overflow timing is checked cycle by cycle against a count of clocks since the enable write. The sampling divider is checked by counting its highs over a fixed window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_RELOAD = 3'd1;
  localparam logic [2:0] A_PSC    = 3'd2;
  localparam logic [2:0] A_CMP    = 3'd3;
  localparam logic [2:0] A_GEN    = 3'd4;
  localparam logic [2:0] A_STAT   = 3'd6;

  localparam logic [2:0] R_CTRL    = 3'd0;
  localparam logic [2:0] R_COUNT   = 3'd1;
  localparam logic [2:0] R_RLD_SH  = 3'd2;
  localparam logic [2:0] R_PSC_SH  = 3'd3;
  localparam logic [2:0] R_CMP_SH  = 3'd4;
  localparam logic [2:0] R_RLD_PRE = 3'd5;
  localparam logic [2:0] R_STAT    = 3'd6;

  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_SUP  = 1;
  localparam int unsigned B_OVFO = 2;
  localparam int unsigned B_BUF  = 7;
  localparam int unsigned B_DIV  = 8;

  localparam int unsigned NBUF    = 3;
  localparam int unsigned IDX_RLD = 0;
  localparam int unsigned IDX_PSC = 1;
  localparam int unsigned IDX_CMP = 2;

  typedef enum logic [1:0] {
    DIV1    = 2'b00,
    DIV2    = 2'b01,
    DIV4    = 2'b10,
    DIV_RSV = 2'b11
  } div_e;

  typedef struct packed {
    div_e div;
    logic buf_en;
    logic ovf_only;
    logic suppress;
    logic en;
  } ctrl_t;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [2:0]                     wsel_i,
  input  logic [CNT_W-1:0]               wdata_i,
  input  logic                           upd_load_i,
  output ctrl_t                          ctrl_o,
  output logic [NBUF-1:0][CNT_W-1:0]     pre_o,
  output logic [NBUF-1:0][CNT_W-1:0]     sh_o,
  output logic                           gen_o,
  output logic                           clr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
    end else if (wr_i && wsel_i == A_CTRL) begin
      ctrl_o.div      <= div_e'(wdata_i[B_DIV+1:B_DIV]);
      ctrl_o.buf_en   <= wdata_i[B_BUF];
      ctrl_o.ovf_only <= wdata_i[B_OVFO];
      ctrl_o.suppress <= wdata_i[B_SUP];
      ctrl_o.en       <= wdata_i[B_EN];
    end
  end

  // one-shot generate command, cleared the next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gen_o <= 1'b0;
    else         gen_o <= wr_i && wsel_i == A_GEN && wdata_i[0];
  end

  assign clr_o = wr_i && wsel_i == A_STAT && wdata_i[0];

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    localparam logic [2:0] MY_SEL = 3'(32'(A_RELOAD) + g);
    logic hit;
    logic direct;

    assign hit    = wr_i && wsel_i == MY_SEL;
    assign direct = (g == IDX_RLD) ? !ctrl_o.buf_en : 1'b0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  pre_o[g] <= '0;
      else if (hit) pre_o[g] <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             sh_o[g] <= '0;
      else if (hit && direct)  sh_o[g] <= wdata_i;
      else if (upd_load_i)     sh_o[g] <= pre_o[g];
    end

    if (g == IDX_RLD) begin : g_rld_chk
      p_buffered_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_o.buf_en && !upd_load_i) |=> $stable(sh_o[g]));
    end else begin : g_oth_chk
      p_suppress_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_o.suppress |=> $stable(sh_o[g]));
    end
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             gen_i,
  input  logic [CNT_W-1:0] psc_lim_i,
  input  logic [CNT_W-1:0] rld_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  logic [CNT_W-1:0] psc_q;
  logic             tick;
  logic             at_top;

  assign tick   = en_i && (psc_q == psc_lim_i) && !gen_i;
  assign at_top = (cnt_o == rld_i);
  assign ovf_o  = tick && at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 psc_q <= '0;
    else if (gen_i)              psc_q <= '0;
    else if (en_i)               psc_q <= (psc_q == psc_lim_i) ? '0 : psc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (gen_i)   cnt_o <= '0;
    else if (tick)    cnt_o <= at_top ? '0 : cnt_o + 1'b1;
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !gen_i) |=> $stable(cnt_o));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_o == '0));

  p_gen_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_i |=> (cnt_o == '0 && psc_q == '0));

endmodule

// File: rtl/tmr_evt.sv
module tmr_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gen_i,
  input  logic ovf_i,
  input  logic suppress_i,
  input  logic ovf_only_i,
  input  logic clr_i,
  output logic upd_load_o,
  output logic uev_o,
  output logic flag_o
);

  logic flag_set;

  assign upd_load_o = !suppress_i && (gen_i || ovf_i);
  assign flag_set   = !suppress_i && (ovf_i || (gen_i && !ovf_only_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) uev_o <= 1'b0;
    else         uev_o <= upd_load_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_o <= 1'b0;
    else if (flag_set) flag_o <= 1'b1;
    else if (clr_i)    flag_o <= 1'b0;
  end

  p_no_uev_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suppress_i |=> !uev_o);

  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  p_ovf_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_only_i && !ovf_i && !flag_o) |=> !flag_o);

  p_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_i && !suppress_i) |=> uev_o);

endmodule

// File: rtl/tmr_fdiv.sv
module tmr_fdiv
  import tmr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  div_e div_i,
  output logic tick_o
);

  logic [1:0] cnt_q;
  logic [1:0] lim;

  always_comb begin
    case (div_i)
      DIV2:    lim = 2'd1;
      DIV4:    lim = 2'd3;
      default: lim = 2'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= (cnt_q >= lim) ? 2'd0 : cnt_q + 2'd1;
  end

  assign tick_o = (cnt_q == 2'd0);

  p_div_gap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((div_i == DIV2 || div_i == DIV4) && tick_o) |=> !tick_o);

  p_div_full_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == DIV1 || div_i == DIV_RSV) |=> tick_o);

endmodule

// File: rtl/upd_timer.sv
module upd_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_wr_i,
  input  logic [2:0]       host_wsel_i,
  input  logic [CNT_W-1:0] host_wdata_i,
  input  logic [2:0]       host_rsel_i,
  output logic [CNT_W-1:0] host_rdata_o,
  output logic             uev_o,
  output logic             upd_flag_o,
  output logic             filt_tick_o
);

  ctrl_t                      ctrl;
  logic [NBUF-1:0][CNT_W-1:0] pre;
  logic [NBUF-1:0][CNT_W-1:0] sh;
  logic                       gen;
  logic                       clr;
  logic                       upd_load;
  logic [CNT_W-1:0]           cnt;
  logic                       ovf;
  logic [CNT_W-1:0]           ctrl_rd;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (host_wr_i),
    .wsel_i     (host_wsel_i),
    .wdata_i    (host_wdata_i),
    .upd_load_i (upd_load),
    .ctrl_o     (ctrl),
    .pre_o      (pre),
    .sh_o       (sh),
    .gen_o      (gen),
    .clr_o      (clr)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ctrl.en),
    .gen_i     (gen),
    .psc_lim_i (sh[IDX_PSC]),
    .rld_i     (sh[IDX_RLD]),
    .cnt_o     (cnt),
    .ovf_o     (ovf)
  );

  tmr_evt u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gen_i      (gen),
    .ovf_i      (ovf),
    .suppress_i (ctrl.suppress),
    .ovf_only_i (ctrl.ovf_only),
    .clr_i      (clr),
    .upd_load_o (upd_load),
    .uev_o      (uev_o),
    .flag_o     (upd_flag_o)
  );

  tmr_fdiv u_fdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (ctrl.div),
    .tick_o (filt_tick_o)
  );

  always_comb begin
    ctrl_rd                   = '0;
    ctrl_rd[B_DIV+1:B_DIV]    = ctrl.div;
    ctrl_rd[B_BUF]            = ctrl.buf_en;
    ctrl_rd[B_OVFO]           = ctrl.ovf_only;
    ctrl_rd[B_SUP]            = ctrl.suppress;
    ctrl_rd[B_EN]             = ctrl.en;
  end

  always_comb begin
    case (host_rsel_i)
      R_CTRL:    host_rdata_o = ctrl_rd;
      R_COUNT:   host_rdata_o = cnt;
      R_RLD_SH:  host_rdata_o = sh[IDX_RLD];
      R_PSC_SH:  host_rdata_o = sh[IDX_PSC];
      R_CMP_SH:  host_rdata_o = sh[IDX_CMP];
      R_RLD_PRE: host_rdata_o = pre[IDX_RLD];
      R_STAT:    host_rdata_o = {{(CNT_W-1){1'b0}}, upd_flag_o};
      default:   host_rdata_o = '0;
    endcase
  end

  p_resv_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rsel_i == R_CTRL) |-> (host_rdata_o[15:10] == '0 && host_rdata_o[6:3] == '0));

endmodule

// File: tb/test_upd_timer.sv
module test_upd_timer;

  localparam logic [15:0] EN   = 16'h0001;
  localparam logic [15:0] SUP  = 16'h0002;
  localparam logic [15:0] OVFO = 16'h0004;
  localparam logic [15:0] BUFE = 16'h0080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  wsel = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [2:0]  rsel = 3'd0;
  logic [15:0] rdata;
  logic        uev;
  logic        flag;
  logic        ftick;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  upd_timer i_upd_timer (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .host_wr_i    (wr),
    .host_wsel_i  (wsel),
    .host_wdata_i (wdata),
    .host_rsel_i  (rsel),
    .host_rdata_o (rdata),
    .uev_o        (uev),
    .upd_flag_o   (flag),
    .filt_tick_o  (ftick)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; wsel = s; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [15:0] d);
    rsel = s;
    #1;
    d = rdata;
  endtask

  // known state: stopped, prescale and reload loaded, counter zero, flag clear
  task automatic start(input logic [15:0] psc, input logic [15:0] rld);
    wr_reg(3'd0, 16'h0000);
    wr_reg(3'd1, rld);
    wr_reg(3'd2, psc);
    wr_reg(3'd4, 16'h0001);
    @(negedge clk);
    wr_reg(3'd6, 16'h0001);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd_reg(3'd0, v); chk("R1 ctrl", v, 16'h0);
    rd_reg(3'd1, v); chk("R1 count", v, 16'h0);
    chk("R1 flag", {15'd0, flag}, 16'h0);
    chk("R1 uev", {15'd0, uev}, 16'h0);
  endtask

  task automatic t_prescale_hold;
    logic [15:0] v, c;
    start(16'd2, 16'd100);
    wr_reg(3'd0, EN);
    repeat (9) @(negedge clk);
    rd_reg(3'd1, v); chk("R2 prescaled count", v, 16'd3);
    wr_reg(3'd0, 16'h0000);
    rd_reg(3'd1, c);
    repeat (5) @(negedge clk);
    rd_reg(3'd1, v); chk("R2 hold while disabled", v, c);
  endtask

  task automatic t_gen_stopped;
    logic [15:0] v;
    rd_reg(3'd1, v); chk("R7 count nonzero before", {15'd0, v != 0}, 16'd1);
    wr_reg(3'd4, 16'h0001);
    chk("R10 no pulse yet", {15'd0, uev}, 16'd0);
    @(negedge clk);
    rd_reg(3'd1, v); chk("R7 count zeroed", v, 16'd0);
    chk("R10 pulse", {15'd0, uev}, 16'd1);
    @(negedge clk);
    chk("R10 pulse one cycle R7 self-clear", {15'd0, uev}, 16'd0);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    int npulse = 0;
    start(16'd0, 16'd3);
    wr_reg(3'd0, EN);
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      rd_reg(3'd1, v);
      chk("R3 count sequence", v, 16'(i % 4));
      chk("R10 overflow pulse", {15'd0, uev}, {15'd0, (i % 4) == 0});
      if (uev) npulse++;
    end
    chk("R10 pulse count", 16'(npulse), 16'd3);
    chk("R8 overflow sets flag", {15'd0, flag}, 16'd1);
    wr_reg(3'd0, 16'h0000);
  endtask

  task automatic t_buffering;
    logic [15:0] v, cmp0;
    start(16'd0, 16'h0010);
    rd_reg(3'd4, cmp0);
    wr_reg(3'd1, 16'h0055);
    rd_reg(3'd2, v); chk("R4 direct reload", v, 16'h0055);
    wr_reg(3'd0, BUFE);
    wr_reg(3'd1, 16'h0077);
    rd_reg(3'd2, v); chk("R5 reload shadow held", v, 16'h0055);
    rd_reg(3'd5, v); chk("R5 reload preload", v, 16'h0077);
    wr_reg(3'd2, 16'd3);
    wr_reg(3'd3, cmp0 + 16'd9);
    rd_reg(3'd3, v); chk("R5 prescale shadow held", v, 16'd0);
    rd_reg(3'd4, v); chk("R5 compare shadow held", v, cmp0);
    wr_reg(3'd4, 16'h0001);
    @(negedge clk);
    rd_reg(3'd2, v); chk("R5 reload loaded", v, 16'h0077);
    rd_reg(3'd3, v); chk("R5 prescale loaded", v, 16'd3);
    rd_reg(3'd4, v); chk("R5 compare loaded", v, cmp0 + 16'd9);
  endtask

  task automatic t_suppress;
    logic [15:0] v, cmp0;
    int bad = 0;
    start(16'd0, 16'd2);
    rd_reg(3'd4, cmp0);
    wr_reg(3'd0, BUFE | SUP | EN);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (uev || flag) bad++;
    end
    chk("R6 overflow gives no pulse or flag", 16'(bad), 16'd0);
    wr_reg(3'd1, 16'd9);
    wr_reg(3'd2, 16'd4);
    wr_reg(3'd3, cmp0 + 16'd5);
    wr_reg(3'd4, 16'h0001);
    @(negedge clk);
    rd_reg(3'd1, v); chk("R6 generate still zeroes", v, 16'd0);
    chk("R6 no pulse", {15'd0, uev}, 16'd0);
    rd_reg(3'd2, v); chk("R6 reload shadow kept", v, 16'd2);
    rd_reg(3'd3, v); chk("R6 prescale shadow kept", v, 16'd0);
    rd_reg(3'd4, v); chk("R6 compare shadow kept", v, cmp0);
    chk("R6 no flag", {15'd0, flag}, 16'd0);
    // prescaler restarted: counts one per clock after the zeroing edge
    @(negedge clk);
    rd_reg(3'd1, v); chk("R6 counter restarts", v, 16'd1);
    wr_reg(3'd0, 16'h0000);
  endtask

  task automatic t_flag_source;
    start(16'd0, 16'd100);
    wr_reg(3'd0, 16'h0000);
    wr_reg(3'd4, 16'h0001);
    @(negedge clk);
    chk("R8 generate sets flag", {15'd0, flag}, 16'd1);
    start(16'd0, 16'd100);
    wr_reg(3'd0, OVFO);
    wr_reg(3'd4, 16'h0001);
    @(negedge clk);
    chk("R8 pulse with overflow-only", {15'd0, uev}, 16'd1);
    chk("R8 no flag from generate", {15'd0, flag}, 16'd0);
    start(16'd0, 16'd2);
    wr_reg(3'd0, OVFO | EN);
    repeat (5) @(negedge clk);
    chk("R8 overflow sets flag", {15'd0, flag}, 16'd1);
    wr_reg(3'd0, 16'h0000);
  endtask

  task automatic t_flag_clear;
    logic [15:0] v;
    repeat (10) @(negedge clk);
    chk("R9 flag sticky", {15'd0, flag}, 16'd1);
    wr_reg(3'd6, 16'h0000);
    chk("R9 zero write keeps flag", {15'd0, flag}, 16'd1);
    wr_reg(3'd6, 16'h0001);
    chk("R9 flag cleared", {15'd0, flag}, 16'd0);
    rd_reg(3'd6, v); chk("R9 status readback", v, 16'd0);
  endtask

  task automatic t_filter;
    int exp [4] = '{8, 4, 2, 8};
    for (int d = 0; d < 4; d++) begin
      int n = 0;
      wr_reg(3'd0, 16'(d) << 8);
      repeat (3) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (ftick) n++;
      end
      chk("R11 sampling rate", 16'(n), 16'(exp[d]));
    end
    wr_reg(3'd0, 16'h0000);
  endtask

  task automatic t_reserved;
    logic [15:0] v;
    wr_reg(3'd0, 16'hFFFF);
    rd_reg(3'd0, v); chk("R12 reserved read zero", v, 16'h0387);
    wr_reg(3'd0, 16'h0000);
    rd_reg(3'd0, v); chk("R12 control cleared", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_prescale_hold;
    t_gen_stopped;
    t_wrap;
    t_buffering;
    t_suppress;
    t_flag_source;
    t_flag_clear;
    t_filter;
    t_reserved;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

endmodule